// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block steps a small microcontroller through four operating modes and produces the clock enables for the CPU, the fast oscillator, the slow oscillator and the wake-up timer. It also drives a two-bit system clock divider select. The block runs on an always-present reference clock `clk`. The slow oscillator output enters as `slow_clk`, passes through a synchronizer, and its rising edges are the only instants at which a run-mode or sleep change is applied. The one exception is leaving the all-off mode, because the slow oscillator is stopped there.

Software writes a request with a target mode, a keep-fast bit and a divider select. The request is held until the next slow-clock edge and then applied. A wake event arriving while a sleep request is still pending cancels that request. In the light sleep mode, wake-up comes from the wake-up timer, from source flags or from a change on an enabled port pin. In the deep sleep mode the wake-up timer is off, so only the flags and the pins can wake the device. On wake-up the controller returns to the run mode that was active before sleep. If that mode needs the fast oscillator, the controller first holds the oscillator on for a fixed number of slow-clock edges before it restarts the CPU.

Top module: `pmc_power_ctrl`

## Requirements
- R1: After reset the mode is FAST (`cur_mode` = 0), all four enables are 1, `sys_div` is 0 and `fast_settling` is 0.
- R2: Mode codes are FAST=0, SLOW=1, IDLE=2, STOP=3. The enables {cpu, fast osc, slow osc, wake timer} are 1111 in FAST, 0011 in IDLE and 0000 in STOP.
- R3: In SLOW the enables are {1, keep, 1, 1}, where keep is the keep-fast bit of the request that selected SLOW.
- R4: Mode changes and divider changes are applied only on a synchronized rising edge of `slow_clk`. The only exception is the exit from STOP.
- R5: `sys_div` takes the 2-bit divider field of an applied request (0..3 selecting divide by 1, 2, 4 or 8).
- R6: A wake event in IDLE takes effect on the next slow-clock edge. A wake event in STOP takes effect on the next `clk` cycle. In both cases the controller returns to the run mode, and the keep bit, that were active before sleep.
- R7: When the mode being returned to needs the fast oscillator (FAST, or SLOW with keep=1), and that oscillator is off, `fast_settling` is 1 and the fast enable is 1 for SETTLE_TICKS slow-clock edges. During this time the CPU enable is 0 when the device is waking from sleep, and 1 when the change is a run-mode change.
- R8: A wake event on the cycle of a sleep request, or on any later cycle before that request is applied, cancels the request. The mode and the divider then stay as they were.
- R9: A rising or falling edge on a port pin whose `pin_en` bit is 1 gives a one-cycle `pin_irq` pulse and is a wake source. An edge on a pin whose `pin_en` bit is 0 has no effect.
- R10: `wkt_event` wakes the device from IDLE. It is ignored in STOP, where the wake-up timer is disabled.
- R11: A request is ignored while the CPU enable is 0.
- R12: Any bit of `src_flag` set to 1 is a wake source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk | input | 1 | Slow oscillator output, asynchronous |
| req_valid | input | 1 | One-cycle mode-request strobe |
| req_mode | input | 2 | Requested mode code |
| req_keep_fast | input | 1 | Keep the fast oscillator on in SLOW |
| req_div | input | 2 | Requested divider select |
| wkt_event | input | 1 | Wake-up timer expiry pulse |
| src_flag | input | N_SRC | Interrupt/wake flags from other sources |
| pin_in | input | N_PIN | Port pin levels, asynchronous |
| pin_en | input | N_PIN | Per-pin change-wake enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| fosc_en | output | 1 | Fast oscillator enable |
| sosc_en | output | 1 | Slow oscillator enable |
| wkt_en | output | 1 | Wake-up timer enable |
| sys_div | output | 2 | System clock divider select |
| cur_mode | output | 2 | Current mode code (the target mode while settling) |
| fast_settling | output | 1 | Fast oscillator settle phase active |
| pin_irq | output | 1 | Pin-change interrupt pulse |

## Verification
The hardest case to reach from the ports is a wake that lands exactly on the cycle of a sleep request. The bench raises a source flag in the same cycle as the request strobe. A second timing-sensitive case is the STOP exit, which must not wait for a slow edge. The bench waits for a `slow_clk` rise, then wakes the device a few cycles later, so the next slow edge lies well after the point where the mode is checked. The settle window is measured in cycles against SETTLE_TICKS slow periods. A random phase picks run modes, divider codes, sleep depths and wake sources from a fixed seed.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_FAST = 2'd0,
        MODE_SLOW = 2'd1,
        MODE_IDLE = 2'd2,
        MODE_STOP = 2'd3
    } pmode_e;

    typedef enum logic [2:0] {
        ST_FAST,
        ST_SLOW,
        ST_IDLE,
        ST_STOP,
        ST_WARM
    } pstate_e;

    typedef struct packed {
        logic cpu;
        logic fosc;
        logic sosc;
        logic wkt;
    } clk_en_t;

    typedef struct packed {
        pmode_e     mode;
        logic       keep_fast;
        logic [1:0] div;
    } mode_req_t;

    function automatic logic is_sleep(pmode_e m);
        return (m == MODE_IDLE) || (m == MODE_STOP);
    endfunction

    function automatic logic needs_fast(pmode_e m, logic keep);
        return (m == MODE_FAST) || ((m == MODE_SLOW) && keep);
    endfunction

    function automatic clk_en_t state_enables(pstate_e st, logic keep, logic warm_cpu);
        clk_en_t e;
        case (st)
            ST_FAST: e = '{cpu: 1'b1, fosc: 1'b1, sosc: 1'b1, wkt: 1'b1};
            ST_SLOW: e = '{cpu: 1'b1, fosc: keep, sosc: 1'b1, wkt: 1'b1};
            ST_IDLE: e = '{cpu: 1'b0, fosc: 1'b0, sosc: 1'b1, wkt: 1'b1};
            ST_WARM: e = '{cpu: warm_cpu, fosc: 1'b1, sosc: 1'b1, wkt: 1'b1};
            default: e = '{cpu: 1'b0, fosc: 1'b0, sosc: 1'b0, wkt: 1'b0};
        endcase
        return e;
    endfunction

    function automatic pmode_e state_mode(pstate_e st, pmode_e run_mode);
        case (st)
            ST_FAST: return MODE_FAST;
            ST_SLOW: return MODE_SLOW;
            ST_IDLE: return MODE_IDLE;
            ST_STOP: return MODE_STOP;
            default: return run_mode;
        endcase
    endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] pipe;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[STAGES-2:0], d};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe[0] <= d;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q_prev <= '0;
        else     q_prev <= pipe[LAST];
    end

    assign q = pipe[LAST];
endmodule

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect #(
    parameter int N_PIN = 4,
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_PIN-1:0] pin_now,
    input  logic [N_PIN-1:0] pin_before,
    input  logic [N_PIN-1:0] pin_en,
    input  logic [N_SRC-1:0] src_flag,
    input  logic             wkt_event,
    input  logic             wkt_en,
    output logic             wake,
    output logic             pin_irq
);
    logic [N_PIN-1:0] pin_hit;
    logic             pin_any;

    assign pin_hit = (pin_now ^ pin_before) & pin_en;
    assign pin_any = |pin_hit;
    assign wake    = pin_any | (|src_flag) | (wkt_event & wkt_en);

    always_ff @(posedge clk) begin
        if (rst) pin_irq <= 1'b0;
        else     pin_irq <= pin_any;
    end

    // A pulse can only follow a change on an enabled pin.
    assert_pin_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (((pin_now ^ pin_before) & pin_en) == '0) |=> !pin_irq);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int SETTLE_TICKS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      slow_edge,
    input  logic      req_valid,
    input  mode_req_t req,
    input  logic      wake,
    output pstate_e   state,
    output pmode_e    run_mode,
    output logic      keep_q,
    output logic      warm_cpu,
    output logic [1:0] div_q
);
    localparam int CW = $clog2(SETTLE_TICKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_TICKS - 1);

    mode_req_t     pend;
    logic          pend_valid;
    logic          pend_abort;
    logic          wake_pend;
    logic [CW-1:0] cnt;
    logic          fast_on;
    logic          running;

    assign running = (state == ST_FAST) || (state == ST_SLOW);
    assign fast_on = (state == ST_FAST) || ((state == ST_SLOW) && keep_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_FAST;
            run_mode   <= MODE_FAST;
            keep_q     <= 1'b0;
            warm_cpu   <= 1'b0;
            div_q      <= 2'd0;
            pend       <= '{mode: MODE_FAST, keep_fast: 1'b0, div: 2'd0};
            pend_valid <= 1'b0;
            pend_abort <= 1'b0;
            wake_pend  <= 1'b0;
            cnt        <= '0;
        end else begin
            if (req_valid) begin
                pend       <= req;
                pend_valid <= 1'b1;
                pend_abort <= wake;
            end else if (wake && pend_valid) begin
                pend_abort <= 1'b1;
            end

            case (state)
                ST_FAST, ST_SLOW: begin
                    if (slow_edge && pend_valid && !req_valid) begin
                        pend_valid <= 1'b0;
                        pend_abort <= 1'b0;
                        if (is_sleep(pend.mode)) begin
                            if (!(pend_abort || wake)) begin
                                state     <= (pend.mode == MODE_IDLE) ? ST_IDLE : ST_STOP;
                                div_q     <= pend.div;
                                wake_pend <= 1'b0;
                            end
                        end else begin
                            run_mode <= pend.mode;
                            keep_q   <= pend.keep_fast;
                            div_q    <= pend.div;
                            if (needs_fast(pend.mode, pend.keep_fast) && !fast_on) begin
                                state    <= ST_WARM;
                                warm_cpu <= 1'b1;
                                cnt      <= '0;
                            end else begin
                                state <= (pend.mode == MODE_FAST) ? ST_FAST : ST_SLOW;
                            end
                        end
                    end
                end
                ST_IDLE, ST_STOP: begin
                    if (wake) wake_pend <= 1'b1;
                    if ((wake || wake_pend) && (slow_edge || state == ST_STOP)) begin
                        wake_pend <= 1'b0;
                        if (needs_fast(run_mode, keep_q)) begin
                            state    <= ST_WARM;
                            warm_cpu <= 1'b0;
                            cnt      <= '0;
                        end else begin
                            state <= ST_SLOW;
                        end
                    end
                end
                default: begin
                    if (slow_edge) begin
                        if (cnt == CNT_LAST)
                            state <= (run_mode == MODE_FAST) ? ST_FAST : ST_SLOW;
                        else
                            cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assert_mode_on_slow_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (!slow_edge && state != ST_STOP) |=> $stable(state));

    assert_div_on_slow_edge_R5: assert property (@(posedge clk) disable iff (rst)
        !slow_edge |=> $stable(div_q));

    assert_wake_aborts_sleep_R8: assert property (@(posedge clk) disable iff (rst)
        (running && slow_edge && pend_valid && !req_valid && is_sleep(pend.mode) && wake)
        |=> (state == ST_FAST || state == ST_SLOW));

    assert_idle_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && slow_edge && wake) |=> (state == ST_WARM || state == ST_SLOW));

    assert_settle_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WARM) |-> (cnt < CW'(SETTLE_TICKS)));
endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
    import pmc_pkg::*;
#(
    parameter int N_PIN        = 4,
    parameter int N_SRC        = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int SETTLE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_clk,
    input  logic             req_valid,
    input  logic [1:0]       req_mode,
    input  logic             req_keep_fast,
    input  logic [1:0]       req_div,
    input  logic             wkt_event,
    input  logic [N_SRC-1:0] src_flag,
    input  logic [N_PIN-1:0] pin_in,
    input  logic [N_PIN-1:0] pin_en,
    output logic             cpu_clk_en,
    output logic             fosc_en,
    output logic             sosc_en,
    output logic             wkt_en,
    output logic [1:0]       sys_div,
    output logic [1:0]       cur_mode,
    output logic             fast_settling,
    output logic             pin_irq
);
    logic             slow_q, slow_prev, slow_edge;
    logic [N_PIN-1:0] pin_q, pin_prev;
    logic             wake;
    pstate_e          state;
    pmode_e           run_mode;
    logic             keep_q, warm_cpu;
    clk_en_t          en;
    mode_req_t        req;

    pmc_sync #(.W(1), .STAGES(SYNC_STAGES)) i_slow_sync (
        .clk(clk), .rst(rst), .d(slow_clk), .q(slow_q), .q_prev(slow_prev)
    );

    pmc_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) i_pin_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_q), .q_prev(pin_prev)
    );

    assign slow_edge = slow_q & ~slow_prev;
    assign en        = state_enables(state, keep_q, warm_cpu);
    assign req       = '{mode: pmode_e'(req_mode), keep_fast: req_keep_fast, div: req_div};

    pmc_wake_detect #(.N_PIN(N_PIN), .N_SRC(N_SRC)) i_wake (
        .clk(clk), .rst(rst), .pin_now(pin_q), .pin_before(pin_prev), .pin_en(pin_en),
        .src_flag(src_flag), .wkt_event(wkt_event), .wkt_en(en.wkt),
        .wake(wake), .pin_irq(pin_irq)
    );

    pmc_mode_fsm #(.SETTLE_TICKS(SETTLE_TICKS)) i_fsm (
        .clk(clk), .rst(rst), .slow_edge(slow_edge),
        .req_valid(req_valid & en.cpu), .req(req), .wake(wake),
        .state(state), .run_mode(run_mode), .keep_q(keep_q),
        .warm_cpu(warm_cpu), .div_q(sys_div)
    );

    assign cpu_clk_en    = en.cpu;
    assign fosc_en       = en.fosc;
    assign sosc_en       = en.sosc;
    assign wkt_en        = en.wkt;
    assign cur_mode      = state_mode(state, run_mode);
    assign fast_settling = (state == ST_WARM);

    assert_stop_all_off_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_STOP && !fast_settling) |-> !(cpu_clk_en | fosc_en | sosc_en | wkt_en));

    assert_stop_ignores_wkt_R10: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_STOP && !fast_settling && src_flag == '0 &&
         ((pin_q ^ pin_prev) & pin_en) == '0) |=> (cur_mode == MODE_STOP));

    assert_no_req_asleep_R11: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_IDLE && !slow_edge) |=> (cur_mode == MODE_IDLE));
endmodule

// File: tb/test_pmc_power_ctrl.sv
module test_pmc_power_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_PIN      = 4;
    localparam int N_SRC      = 3;
    localparam int SETTLE     = 4;
    localparam int SLOW_HALF  = 8;
    localparam int SLOW_PER   = 2 * SLOW_HALF;

    logic clk = 1'b0, rst = 1'b1, slow_clk = 1'b0;
    logic req_valid = 1'b0, req_keep_fast = 1'b0, wkt_event = 1'b0;
    logic [1:0] req_mode = 2'd0, req_div = 2'd0;
    logic [N_SRC-1:0] src_flag = '0;
    logic [N_PIN-1:0] pin_in = '0, pin_en = 4'b0101;
    logic cpu_clk_en, fosc_en, sosc_en, wkt_en, fast_settling, pin_irq;
    logic [1:0] sys_div, cur_mode;

    int checks = 0, fails = 0, irq_count = 0, since_rise = 0, slow_cnt = 0;
    bit done = 1'b0;
    logic [1:0] last_mode = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmc_power_ctrl #(.N_PIN(N_PIN), .N_SRC(N_SRC), .SETTLE_TICKS(SETTLE)) i_pmc_power_ctrl (
        .clk(clk), .rst(rst), .slow_clk(slow_clk), .req_valid(req_valid),
        .req_mode(req_mode), .req_keep_fast(req_keep_fast), .req_div(req_div),
        .wkt_event(wkt_event), .src_flag(src_flag), .pin_in(pin_in), .pin_en(pin_en),
        .cpu_clk_en(cpu_clk_en), .fosc_en(fosc_en), .sosc_en(sosc_en), .wkt_en(wkt_en),
        .sys_div(sys_div), .cur_mode(cur_mode), .fast_settling(fast_settling), .pin_irq(pin_irq)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Slow clock, pin_irq counter and the mode-change timing monitor (R4).
    always @(negedge clk) begin
        slow_cnt <= (slow_cnt == SLOW_HALF - 1) ? 0 : slow_cnt + 1;
        if (slow_cnt == SLOW_HALF - 1) begin
            slow_clk <= ~slow_clk;
            if (!slow_clk) since_rise <= 0; else since_rise <= since_rise + 1;
        end else since_rise <= since_rise + 1;
        if (!rst) begin
            if (pin_irq) irq_count <= irq_count + 1;
            if (cur_mode != last_mode && last_mode != 2'd3)
                check("R4 change near slow edge", int'(since_rise >= 1 && since_rise <= 4), 1);
        end
        last_mode <= cur_mode;
    end

    function automatic logic [3:0] exp_en(int mode, bit keep);
        case (mode)
            0: return 4'b1111;
            1: return {1'b1, keep, 2'b11};
            2: return 4'b0011;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int needs_warm(int mode, bit keep);
        return int'(mode == 0 || (mode == 1 && keep));
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(int mode, bit keep, int div);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'(mode); req_keep_fast = keep; req_div = 2'(div);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_mode(string tag, int mode, bit keep);
        check({tag, " mode"}, int'(cur_mode), mode);
        check({tag, " enables"}, int'({cpu_clk_en, fosc_en, sosc_en, wkt_en}), int'(exp_en(mode, keep)));
    endtask

    task automatic measure_warm(output int n, output int cpu_seen);
        n = 0; cpu_seen = 0;
        for (int i = 0; i < 12 * SLOW_PER; i++) begin
            @(negedge clk);
            if (fast_settling) begin
                n++;
                if (cpu_clk_en) cpu_seen = 1;
            end else if (n > 0) break;
        end
    endtask

    task automatic wake_by(int kind);
        @(negedge clk);
        case (kind)
            0: begin src_flag = 3'b010; @(negedge clk); src_flag = '0; end
            1: pin_in[2] = ~pin_in[2];
            default: begin wkt_event = 1'b1; @(negedge clk); wkt_event = 1'b0; end
        endcase
    endtask

    initial begin
        int n, c, m, k, d, sleep, src, base;
        void'($urandom(32'd2024));
        step(5);
        rst = 1'b0;
        step(1);
        // R1 reset state
        check_mode("R1 reset", 0, 1'b0);
        check("R1 div", int'(sys_div), 0);
        check("R1 settling", int'(fast_settling), 0);

        // R4/R5 divider applied only at slow edge
        @(negedge slow_clk);
        request(0, 1'b0, 2);
        step(2);
        check("R4 div held before edge", int'(sys_div), 0);
        step(20);
        check("R5 div applied", int'(sys_div), 2);

        // R3 slow without and with fast oscillator
        request(1, 1'b0, 1);
        step(3 * SLOW_PER);
        check_mode("R3 slow keep0", 1, 1'b0);
        check("R5 div 1", int'(sys_div), 1);
        request(1, 1'b1, 1);
        measure_warm(n, c);
        check("R7 run-change settle cycles", n, SETTLE * SLOW_PER);
        check("R7 cpu runs during run-change settle", c, 1);
        step(3);
        check_mode("R3 slow keep1", 1, 1'b1);

        // IDLE from FAST, R11 ignored request, R10 wake timer, R7 settle
        request(0, 1'b0, 3);
        step(3 * SLOW_PER);
        check_mode("R2 fast", 0, 1'b0);
        request(2, 1'b0, 3);
        step(3 * SLOW_PER);
        check_mode("R2 idle", 2, 1'b0);
        request(1, 1'b0, 0);
        step(3 * SLOW_PER);
        check("R11 request ignored asleep", int'(cur_mode), 2);
        check("R11 div unchanged", int'(sys_div), 3);
        wake_by(2);
        measure_warm(n, c);
        check("R7 idle-wake settle cycles", n, SETTLE * SLOW_PER);
        check("R7 cpu off while settling from sleep", c, 0);
        step(2);
        check_mode("R6 back to fast", 0, 1'b0);

        // STOP from SLOW keep0: wake timer and disabled pin ignored (R10, R9)
        request(1, 1'b0, 0);
        step(3 * SLOW_PER);
        request(3, 1'b0, 0);
        step(3 * SLOW_PER);
        check_mode("R2 stop", 3, 1'b0);
        wkt_event = 1'b1; step(1); wkt_event = 1'b0;
        step(2 * SLOW_PER);
        check("R10 wkt ignored in stop", int'(cur_mode), 3);
        base = irq_count;
        pin_in[1] = ~pin_in[1];
        step(2 * SLOW_PER);
        check("R9 disabled pin ignored", int'(cur_mode), 3);
        check("R9 no irq from disabled pin", irq_count - base, 0);
        @(posedge slow_clk);
        step(2);
        pin_in[0] = ~pin_in[0];
        step(5);
        check("R6 stop exit without slow edge", int'(cur_mode), 1);
        check_mode("R6 back to slow keep0", 1, 1'b0);
        check("R9 one irq pulse", irq_count - base, 1);

        // STOP from FAST, flag wake, settle window R7/R12
        request(0, 1'b0, 0);
        measure_warm(n, c);
        step(3);
        request(3, 1'b0, 0);
        step(3 * SLOW_PER);
        check("R2 stop again", int'(cur_mode), 3);
        wake_by(0);
        measure_warm(n, c);
        check("R12 flag wake settle window", int'(n > (SETTLE - 1) * SLOW_PER && n <= SETTLE * SLOW_PER), 1);
        step(2);
        check_mode("R6 stop back to fast", 0, 1'b0);

        // R8 wake on the request cycle aborts sleep
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'd2; req_div = 2'd1; src_flag = 3'b001;
        @(negedge clk);
        req_valid = 1'b0; src_flag = '0;
        step(3 * SLOW_PER);
        check_mode("R8 sleep aborted", 0, 1'b0);
        check("R8 div kept", int'(sys_div), 0);

        // Random phase
        for (int it = 0; it < 20; it++) begin
            m = int'($urandom_range(0, 1));
            k = int'($urandom_range(0, 1));
            d = int'($urandom_range(0, 3));
            request(m, k[0], d);
            step(6 * SLOW_PER);
            check_mode("R2 R3 random run", m, k[0]);
            check("R5 random div", int'(sys_div), d);
            sleep = int'($urandom_range(2, 3));
            request(sleep, 1'b0, d);
            step(3 * SLOW_PER);
            check("R2 random sleep", int'(cur_mode), sleep);
            src = (sleep == 2) ? int'($urandom_range(0, 2)) : int'($urandom_range(0, 1));
            wake_by(src);
            step((needs_warm(m, k[0]) != 0) ? (SETTLE + 3) * SLOW_PER : 3 * SLOW_PER);
            check_mode("R6 R12 random return", m, k[0]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule